// File: doc/BRIEF.md
# Write-Once Option Register Pair

This block holds two byte-wide option registers that sit on a simple memory-mapped bus with an address, a write strobe, write data and read data. Software gets one chance to program each register after a reset. The first bus write to a register's address loads its option bits and locks that register. Every later write to the same address is dropped until the next reset. The option bits leave the block as level signals, one wire per option, and feed the clock, low-voltage, stop-mode and watchdog logic elsewhere on the chip.

The low-voltage trip-level option has its own reset domain. Only the power-on reset clears it, and it has a separate write-once lock. An ordinary reset re-arms every other option. It leaves the trip level and its lock exactly as they were, so the trip level can be programmed once per power-up. The power-on reset input also drives the ordinary reset path. Both reset inputs are synchronous and active high.

Top module: `cfgreg_pair`

## Requirements
- R1: While the power-on reset is asserted, and after it is released, every option output is 0, and reads of address 0x1E and address 0x1F return 0x00.
- R2: The first write to address 0x1E after any reset loads write-data bits 1 and 0 into the register. Bit 1 drives `opt_osc_run_in_stop` and bit 0 drives `opt_sci_clk_src`. Read bits 7 to 2 at this address are always 0.
- R3: Once address 0x1E has been written, later writes to it leave both of its options unchanged until a reset.
- R4: The first write to address 0x1F after a power-on reset loads all eight bits. From bit 7 down to bit 0 the bits are: watchdog prescale, low-voltage detect in stop, low-voltage reset disable, low-voltage power disable, trip level (bit 3), short stop recovery, stop enable and watchdog disable.
- R5: Once address 0x1F has been written, later writes to it leave its seven non-trip bits unchanged until a reset.
- R6: An ordinary reset clears both registers and both register locks. The trip-level bit keeps its value through that reset.
- R7: After an ordinary reset with no power-on reset, a write to address 0x1F loads the seven non-trip bits and leaves the trip-level bit unchanged.
- R8: A power-on reset clears the trip-level bit and re-arms it, so the next write to address 0x1F loads it.
- R9: A write locks its register whatever the data value, including all zeros.
- R10: Writes to any address other than 0x1E and 0x1F change no option, lock or read value. Reads of such addresses return 0x00.
- R11: Reads have no side effects. Reading either register does not lock it.
- R12: Each option output is equal to the corresponding bit in the read-back value of its register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst | input | 1 | Ordinary reset, synchronous, active high |
| por_rst | input | 1 | Power-on reset, synchronous, active high; also resets the ordinary domain |
| bus_addr | input | 8 | Bus address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| opt_osc_run_in_stop | output | 1 | 1 keeps the oscillator running in stop mode |
| opt_sci_clk_src | output | 1 | Serial baud clock source select |
| opt_wdog_prescale | output | 1 | Watchdog prescale select |
| opt_lv_stop_en | output | 1 | Low-voltage detect enabled in stop |
| opt_lv_rst_dis | output | 1 | Low-voltage reset disable |
| opt_lv_pwr_dis | output | 1 | Low-voltage detector power disable |
| opt_lv_trip_5v | output | 1 | Trip level select, 1 = 5 V, 0 = 3 V |
| opt_short_recover | output | 1 | Short stop-recovery select |
| opt_stop_en | output | 1 | Stop instruction enable |
| opt_wdog_dis | output | 1 | Watchdog disable |

## Verification
The bench writes three kinds of data. All-ones shows that only the implemented bits of address 0x1E are stored. Mixed patterns such as 0xAD and 0xF7 catch bits that are swapped or mapped to the wrong output. All-zeros shows that a write locks even when it changes no bit. Writes to each register are repeated with different data, so a lock that fails to set is caught. The same sequences are repeated after an ordinary reset and after a power-on reset, which separates the trip-level domain from the rest. Unmapped writes and plain reads are placed before a first real write, so any hidden locking shows up in the value that write leaves behind.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

    localparam int ADDR_W   = 8;
    localparam int REG_W    = 8;
    localparam int TRIP_BIT = 3;

    localparam logic [ADDR_W-1:0] ADDR_OPT_B = 8'h1E;
    localparam logic [ADDR_W-1:0] ADDR_OPT_A = 8'h1F;

    // implemented bits of each register
    localparam logic [REG_W-1:0] MASK_OPT_B   = 8'h03;
    localparam logic [REG_W-1:0] MASK_TRIP    = REG_W'(1) << TRIP_BIT;
    localparam logic [REG_W-1:0] MASK_OPT_A   = ~MASK_TRIP;

    typedef struct packed {
        logic wdog_prescale;
        logic lv_stop_en;
        logic lv_rst_dis;
        logic lv_pwr_dis;
        logic lv_trip_5v;
        logic short_recover;
        logic stop_en;
        logic wdog_dis;
    } opt_a_t;

    typedef struct packed {
        logic [REG_W-3:0] unused;
        logic             osc_run_in_stop;
        logic             sci_clk_src;
    } opt_b_t;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_OPT_B = 2'd1,
        SEL_OPT_A = 2'd2
    } sel_e;

    // Insert the separately held trip bit into the register image.
    function automatic logic [REG_W-1:0] merge_trip(input logic [REG_W-1:0] body,
                                                    input logic             trip);
        logic [REG_W-1:0] r;
        r = body & MASK_OPT_A;
        r[TRIP_BIT] = trip;
        return r;
    endfunction

endpackage

// File: rtl/cfgreg_decode.sv
module cfgreg_decode
    import cfgreg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [REG_W-1:0]  img_b,
    input  logic [REG_W-1:0]  img_a,
    output logic              wr_b,
    output logic              wr_a,
    output logic [REG_W-1:0]  rdata
);

    sel_e sel;

    always_comb begin
        if (addr == ADDR_OPT_B)      sel = SEL_OPT_B;
        else if (addr == ADDR_OPT_A) sel = SEL_OPT_A;
        else                         sel = SEL_NONE;
    end

    assign wr_b = wr && (sel == SEL_OPT_B);
    assign wr_a = wr && (sel == SEL_OPT_A);

    always_comb begin
        unique case (sel)
            SEL_OPT_B: rdata = img_b & MASK_OPT_B;
            SEL_OPT_A: rdata = img_a;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/cfgreg_wo_byte.sv
module cfgreg_wo_byte
    import cfgreg_pkg::*;
#(
    parameter logic [REG_W-1:0] IMPL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] q,
    output logic             locked
);

    logic [REG_W-1:0] store;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
        end else if (wr_en) begin
            locked <= 1'b1;
        end
    end

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            always_ff @(posedge clk) begin
                if (rst)                   store[i] <= 1'b0;
                else if (wr_en && !locked) store[i] <= wdata[i];
            end
        end else begin : g_tie
            assign store[i] = 1'b0;
        end
    end

    assign q = store;

endmodule

// File: rtl/cfgreg_por_bit.sv
module cfgreg_por_bit (
    input  logic clk,
    input  logic por_rst,
    input  logic wr_en,
    input  logic d,
    output logic q,
    output logic locked
);

    always_ff @(posedge clk) begin
        if (por_rst) begin
            q      <= 1'b0;
            locked <= 1'b0;
        end else if (wr_en) begin
            if (!locked) q <= d;
            locked <= 1'b1;
        end
    end

endmodule

// File: rtl/cfgreg_pair.sv
module cfgreg_pair
    import cfgreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              por_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              opt_osc_run_in_stop,
    output logic              opt_sci_clk_src,
    output logic              opt_wdog_prescale,
    output logic              opt_lv_stop_en,
    output logic              opt_lv_rst_dis,
    output logic              opt_lv_pwr_dis,
    output logic              opt_lv_trip_5v,
    output logic              opt_short_recover,
    output logic              opt_stop_en,
    output logic              opt_wdog_dis
);

    logic             rst_any;
    logic             wr_b, wr_a;
    logic [REG_W-1:0] q_b, q_a_body;
    logic             lock_b, lock_a;
    logic             trip_q, trip_lock;
    logic [REG_W-1:0] img_a;
    opt_a_t           opt_a;
    opt_b_t           opt_b;

    // power-on reset also drives the ordinary domain
    assign rst_any = rst | por_rst;

    cfgreg_decode u_dec (
        .addr  (bus_addr),
        .wr    (bus_wr),
        .img_b (q_b),
        .img_a (img_a),
        .wr_b  (wr_b),
        .wr_a  (wr_a),
        .rdata (bus_rdata)
    );

    cfgreg_wo_byte #(.IMPL(MASK_OPT_B)) u_reg_b (
        .clk    (clk),
        .rst    (rst_any),
        .wr_en  (wr_b),
        .wdata  (bus_wdata),
        .q      (q_b),
        .locked (lock_b)
    );

    cfgreg_wo_byte #(.IMPL(MASK_OPT_A)) u_reg_a (
        .clk    (clk),
        .rst    (rst_any),
        .wr_en  (wr_a),
        .wdata  (bus_wdata),
        .q      (q_a_body),
        .locked (lock_a)
    );

    cfgreg_por_bit u_trip (
        .clk     (clk),
        .por_rst (por_rst),
        .wr_en   (wr_a),
        .d       (bus_wdata[TRIP_BIT]),
        .q       (trip_q),
        .locked  (trip_lock)
    );

    assign img_a = merge_trip(q_a_body, trip_q);
    assign opt_a = opt_a_t'(img_a);
    assign opt_b = opt_b_t'(q_b);

    assign opt_osc_run_in_stop = opt_b.osc_run_in_stop;
    assign opt_sci_clk_src     = opt_b.sci_clk_src;
    assign opt_wdog_prescale   = opt_a.wdog_prescale;
    assign opt_lv_stop_en      = opt_a.lv_stop_en;
    assign opt_lv_rst_dis      = opt_a.lv_rst_dis;
    assign opt_lv_pwr_dis      = opt_a.lv_pwr_dis;
    assign opt_lv_trip_5v      = opt_a.lv_trip_5v;
    assign opt_short_recover   = opt_a.short_recover;
    assign opt_stop_en         = opt_a.stop_en;
    assign opt_wdog_dis        = opt_a.wdog_dis;

endmodule

// File: rtl/cfgreg_pair_chk.sv
module cfgreg_pair_chk
    import cfgreg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              por_rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [REG_W-1:0]  bus_rdata,
    input logic              opt_osc_run_in_stop,
    input logic              opt_sci_clk_src,
    input logic              opt_lv_trip_5v,
    input logic              opt_wdog_prescale,
    input logic              opt_wdog_dis
);

    logic seen_b    = 1'b0;
    logic seen_a    = 1'b0;
    logic seen_trip = 1'b0;
    logic mapped;
    logic [1:0] opt_b_bits;

    assign mapped     = (bus_addr == ADDR_OPT_B) || (bus_addr == ADDR_OPT_A);
    assign opt_b_bits = {opt_osc_run_in_stop, opt_sci_clk_src};

    always_ff @(posedge clk) begin
        if (rst || por_rst) begin
            seen_b <= 1'b0;
            seen_a <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == ADDR_OPT_B) seen_b <= 1'b1;
            if (bus_wr && bus_addr == ADDR_OPT_A) seen_a <= 1'b1;
        end
        if (por_rst)                                        seen_trip <= 1'b0;
        else if (!rst && bus_wr && bus_addr == ADDR_OPT_A)  seen_trip <= 1'b1;
    end

    AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (rst || por_rst)
        (bus_addr == ADDR_OPT_B) |-> (bus_rdata[REG_W-1:2] == '0)); // R2

    AST_OPT_B_LOCKED: assert property (@(posedge clk) disable iff (rst || por_rst)
        (seen_b && bus_wr && bus_addr == ADDR_OPT_B) |=> $stable(opt_b_bits)); // R3

    AST_OPT_A_LOCKED: assert property (@(posedge clk) disable iff (rst || por_rst)
        (seen_a && bus_wr && bus_addr == ADDR_OPT_A)
        |=> ($stable(opt_wdog_prescale) && $stable(opt_wdog_dis))); // R5

    AST_TRIP_KEPT_ON_RESET: assert property (@(posedge clk) disable iff (por_rst)
        rst |=> $stable(opt_lv_trip_5v)); // R6

    AST_TRIP_ONCE: assert property (@(posedge clk) disable iff (por_rst)
        (seen_trip && bus_wr && bus_addr == ADDR_OPT_A) |=> $stable(opt_lv_trip_5v)); // R7

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst || por_rst)
        !mapped |-> (bus_rdata == '0)); // R10

    AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (rst || por_rst)
        (bus_wr && !mapped) |=> ($stable(opt_b_bits) && $stable(opt_lv_trip_5v))); // R10

endmodule

bind cfgreg_pair cfgreg_pair_chk u_chk (
    .clk                 (clk),
    .rst                 (rst),
    .por_rst             (por_rst),
    .bus_addr            (bus_addr),
    .bus_wr              (bus_wr),
    .bus_rdata           (bus_rdata),
    .opt_osc_run_in_stop (opt_osc_run_in_stop),
    .opt_sci_clk_src     (opt_sci_clk_src),
    .opt_lv_trip_5v      (opt_lv_trip_5v),
    .opt_wdog_prescale   (opt_wdog_prescale),
    .opt_wdog_dis        (opt_wdog_dis)
);

// File: tb/tb_cfgreg_pair.sv
module tb_cfgreg_pair;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       por_rst = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       o_osc, o_sci, o_wp, o_lvs, o_lvr, o_lvp, o_trip, o_ssr, o_stop, o_wd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cfgreg_pair dut (
        .clk                 (clk),
        .rst                 (rst),
        .por_rst             (por_rst),
        .bus_addr            (bus_addr),
        .bus_wr              (bus_wr),
        .bus_wdata           (bus_wdata),
        .bus_rdata           (bus_rdata),
        .opt_osc_run_in_stop (o_osc),
        .opt_sci_clk_src     (o_sci),
        .opt_wdog_prescale   (o_wp),
        .opt_lv_stop_en      (o_lvs),
        .opt_lv_rst_dis      (o_lvr),
        .opt_lv_pwr_dis      (o_lvp),
        .opt_lv_trip_5v      (o_trip),
        .opt_short_recover   (o_ssr),
        .opt_stop_en         (o_stop),
        .opt_wdog_dis        (o_wd)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // one write cycle, driven and released on falling edges
    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, $sformatf("read %02h", a), bus_rdata, exp);
    endtask

    // outputs against expected register images (R12)
    task automatic outs_chk(input string req, input logic [7:0] exp_b, input logic [7:0] exp_a);
        check(req, "opt_b outputs", {6'b0, o_osc, o_sci}, exp_b & 8'h03);
        check(req, "opt_a outputs", {o_wp, o_lvs, o_lvr, o_lvp, o_trip, o_ssr, o_stop, o_wd}, exp_a);
    endtask

    task automatic do_por();
        @(negedge clk); por_rst = 1'b1;
        @(negedge clk); @(negedge clk); por_rst = 1'b0;
    endtask

    task automatic do_rst();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        por_rst = 1'b1;
        @(negedge clk);
        outs_chk("R1", 8'h00, 8'h00);
        por_rst = 1'b0;
        read_chk("R1", 8'h1E, 8'h00);
        read_chk("R1", 8'h1F, 8'h00);
        outs_chk("R1", 8'h00, 8'h00);
    endtask

    task automatic t_opt_b();
        bus_write(8'h1E, 8'hFF);
        read_chk("R2", 8'h1E, 8'h03);
        outs_chk("R12", 8'h03, 8'h00);
        bus_write(8'h1E, 8'h00);
        read_chk("R3", 8'h1E, 8'h03);
        bus_write(8'h1E, 8'h01);
        read_chk("R3", 8'h1E, 8'h03);
    endtask

    task automatic t_opt_a();
        bus_write(8'h1F, 8'hAD);
        read_chk("R4", 8'h1F, 8'hAD);
        outs_chk("R12", 8'h03, 8'hAD);
        bus_write(8'h1F, 8'h52);
        read_chk("R5", 8'h1F, 8'hAD);
    endtask

    task automatic t_soft_reset();
        do_rst();
        read_chk("R6", 8'h1F, 8'h08);
        read_chk("R6", 8'h1E, 8'h00);
        outs_chk("R6", 8'h00, 8'h08);
        bus_write(8'h1E, 8'h02);
        read_chk("R6", 8'h1E, 8'h02);
        bus_write(8'h1F, 8'h70);
        read_chk("R7", 8'h1F, 8'h78);
        bus_write(8'h1F, 8'h00);
        read_chk("R5", 8'h1F, 8'h78);
        outs_chk("R12", 8'h02, 8'h78);
    endtask

    task automatic t_por();
        do_por();
        read_chk("R8", 8'h1F, 8'h00);
        bus_write(8'h1F, 8'h08);
        read_chk("R8", 8'h1F, 8'h08);
        do_por();
        bus_write(8'h1F, 8'hF7);
        read_chk("R8", 8'h1F, 8'hF7);
        outs_chk("R12", 8'h00, 8'hF7);
    endtask

    task automatic t_zero_locks();
        do_por();
        bus_write(8'h1E, 8'h00);
        bus_write(8'h1E, 8'h03);
        read_chk("R9", 8'h1E, 8'h00);
        bus_write(8'h1F, 8'h00);
        bus_write(8'h1F, 8'hFF);
        read_chk("R9", 8'h1F, 8'h00);
    endtask

    task automatic t_unmapped();
        do_por();
        bus_write(8'h1D, 8'hFF);
        bus_write(8'h20, 8'hFF);
        bus_write(8'h9F, 8'hFF);
        read_chk("R10", 8'h1D, 8'h00);
        read_chk("R10", 8'h1E, 8'h00);
        read_chk("R10", 8'h1F, 8'h00);
        bus_write(8'h1E, 8'h01);
        bus_write(8'h1F, 8'h0C);
        read_chk("R10", 8'h1E, 8'h01);
        read_chk("R10", 8'h1F, 8'h0C);
        bus_write(8'h00, 8'hFF);
        read_chk("R10", 8'h1F, 8'h0C);
        read_chk("R10", 8'hFF, 8'h00);
    endtask

    task automatic t_read_no_lock();
        do_por();
        for (int i = 0; i < 4; i++) begin
            read_chk("R11", 8'h1E, 8'h00);
            read_chk("R11", 8'h1F, 8'h00);
        end
        bus_write(8'h1E, 8'h02);
        bus_write(8'h1F, 8'h40);
        read_chk("R11", 8'h1E, 8'h02);
        read_chk("R11", 8'h1F, 8'h40);
        outs_chk("R12", 8'h02, 8'h40);
    endtask

    initial begin
        t_reset();
        t_opt_b();
        t_opt_a();
        t_soft_reset();
        t_por();
        t_zero_locks();
        t_unmapped();
        t_read_no_lock();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=running expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule